// File: doc/BRIEF.md
# Auxiliary ADC Conversion Sequencer

This block sits between a register bus and a multi-channel auxiliary converter and runs one conversion at a time. Software first turns the converter on through a power bit. It may then program a scale and a reference choice into a channel's readback register. A conversion is requested by writing a channel-select bit together with a poll flag into the control register.

The sequencer waits a fixed number of clock cycles, standing in for the analog conversion time, and then captures the converter data input. The captured value goes into the low bits of that channel's readback register, the poll flag clears, and a sticky data-ready interrupt is raised. A host polls the flag or waits for the interrupt, and gives up if the flag is still set about 5 ms after the request. The highest channels (the supply-sense and temperature channels) have their scale and reference fixed at zero.

Top module: `auxadc_seq`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The converter enable is bit 0 of the power register (address 0). While it is clear, a set poll flag starts nothing: the flag stays set, no readback changes and no interrupt is raised. The pending request starts as soon as the enable is set.
- R3: The control register (address 1) holds channel-select bits at positions 0..NCH-1 and the poll flag at bit 15. With the enable set, a write that sets the poll flag and at least one channel bit starts a conversion of the lowest selected channel. The poll flag reads clear exactly CONV_CYCLES+1 clock cycles after that write, and the channel-select bits remain as written.
- R4: On completion, the `adc_din` value present in that cycle is stored in bits 11:0 of the readback register at address RB_BASE+channel. Bits 15:12 of that register are kept.
- R5: For channels below FIXED_LO, a write to the readback register updates only bits 15:13 (scale) and bit 12 (reference). Bits 11:0 cannot be written.
- R6: For channels FIXED_LO and above, writes to the readback register have no effect, and bits 15:12 always read zero.
- R7: Completion sets bit 0 of the interrupt register (address 2), and `irq` follows that bit. The bit stays set until a 1 is written to bit 0; writing 0 does nothing. When completion and a clear fall in the same cycle, the set wins.
- R8: While a conversion is running, writes to the control register are ignored.
- R9: Clearing the enable during a conversion abandons it. The poll flag stays set, no readback changes and no interrupt is raised. Re-enabling restarts the conversion with the full latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| adc_din | input | 12 | Converter result input, captured at completion |
| irq | output | 1 | Data-ready interrupt, sticky |

## Verification
The collision that matters most is a completion landing in the same cycle as a write-one-to-clear of the interrupt bit. The bench makes this happen by counting exactly CONV_CYCLES edges after the poll write and then issuing the clear on the completion edge. It then expects the interrupt to stay asserted, and it also checks that a clear issued one cycle later does take effect. Control writes issued during a running conversion are a second overlap. They are judged by reading back the poll flag, the select bits and the untouched readback registers once the conversion has finished.

// File: rtl/auxadc_seq.sv
module auxadc_seq #(
  parameter int NCH         = 8,
  parameter int AW          = 5,
  parameter int RB_BASE     = 8,
  parameter int FIXED_LO    = 4,
  parameter int CONV_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic [11:0]   adc_din,
  output logic          irq
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW = $clog2(CONV_CYCLES) + 1;
  localparam logic [AW-1:0] A_PWR = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);
  localparam logic [AW-1:0] A_IRQ = AW'(2);

  logic              en_q, poll_q, irq_q, busy_q;
  logic [NCH-1:0]    sel_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     ch_q, low_ch;
  logic [15:0]       rb_q [NCH];

  always_comb begin
    low_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (sel_q[i]) low_ch = IW'(i);
  end

  wire start = !busy_q && en_q && poll_q && (|sel_q);
  wire done  = busy_q && en_q && (cnt_q == '0);
  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; poll_q <= 1'b0; irq_q <= 1'b0; busy_q <= 1'b0;
      sel_q <= '0; cnt_q <= '0; ch_q <= '0;
      for (int i = 0; i < NCH; i++) rb_q[i] <= '0;
    end else begin
      if (wr_en && addr == A_PWR) en_q <= wdata[0];
      if (wr_en && addr == A_CTL && !busy_q) begin
        sel_q  <= wdata[NCH-1:0];
        poll_q <= wdata[15];
      end
      if (wr_en && addr == A_IRQ && wdata[0]) irq_q <= 1'b0;
      for (int i = 0; i < FIXED_LO && i < NCH; i++)
        if (wr_en && addr == AW'(RB_BASE + i)) rb_q[i][15:12] <= wdata[15:12];
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(CONV_CYCLES - 1);
        ch_q   <= low_ch;
      end else if (busy_q) begin
        if (!en_q) busy_q <= 1'b0;
        else if (cnt_q == '0) begin
          busy_q <= 1'b0;
          poll_q <= 1'b0;
          irq_q  <= 1'b1;
          rb_q[ch_q][11:0] <= adc_din;
        end else cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PWR: rdata = {15'd0, en_q};
      A_CTL: rdata = {poll_q, 15'(sel_q)};
      A_IRQ: rdata = {15'd0, irq_q};
      default: for (int i = 0; i < NCH; i++)
                 if (addr == AW'(RB_BASE + i)) rdata = rb_q[i];
    endcase
  end

  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy_q) |=> !busy_q);
  a_r3_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !poll_q);
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(CONV_CYCLES)));
  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == A_IRQ && wdata[0])) |=> irq);
  a_r8_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> ($stable(poll_q) && $stable(sel_q)));
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !en_q) |=> (!busy_q && poll_q));

  for (genvar g = FIXED_LO; g < NCH; g++) begin : g_fix
    a_r6_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rb_q[g][15:12] == 4'd0);
  end
endmodule

// File: tb/sim_auxadc_seq.sv
`timescale 1ns/100ps
module sim_auxadc_seq;
  localparam int NCH = 8, AW = 5, RB_BASE = 8, FIXED_LO = 4, C = 24;
  localparam logic [15:0] POLL = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [11:0] adc_din = '0;
  logic irq;
  int checks = 0, fails = 0;
  logic [15:0] exp_rb [NCH];

  always #2.5 clk = ~clk;

  auxadc_seq #(.NCH(NCH), .AW(AW), .RB_BASE(RB_BASE), .FIXED_LO(FIXED_LO),
               .CONV_CYCLES(C)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .adc_din(adc_din), .irq(irq));

  function automatic logic [15:0] rb_wr(int ch, logic [15:0] old, logic [15:0] w);
    return (ch < FIXED_LO) ? {w[15:12], old[11:0]} : old;
  endfunction
  function automatic logic [15:0] rb_done(logic [15:0] old, logic [11:0] d);
    return {old[15:12], d};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #0.5 v = rdata;
  endtask

  task automatic wait_clear(output int k);
    logic [15:0] v;
    k = 0;
    rd(AW'(1), v);
    while (v[15] && k < 1000) begin k++; rd(AW'(1), v); end
  endtask

  task automatic chk_rb(int ch, string tag);
    logic [15:0] v;
    rd(AW'(RB_BASE + ch), v);
    chk(v == exp_rb[ch], tag, v, exp_rb[ch]);
  endtask

  task automatic convert(int ch, logic [11:0] d, string tag);
    int k;
    logic [15:0] v;
    adc_din = d;
    wr(AW'(1), POLL | 16'(1 << ch));
    wait_clear(k);
    chk(k == C + 1, {tag, " R3 latency"}, k, C + 1);
    exp_rb[ch] = rb_done(exp_rb[ch], d);
    chk_rb(ch, {tag, " R4 result"});
    chk(irq == 1'b1, {tag, " R7 irq set"}, irq, 1);
    wr(AW'(2), 16'h0001);
    rd(AW'(2), v);
    chk(irq == 1'b0 && v == 16'h0, {tag, " R7 irq clear"}, {irq, v}, 0);
  endtask

  initial begin
    #(5ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int k;
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) exp_rb[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(AW'(a), v); chk(v == 16'h0, "R1 reg reset", v, 0);
    end
    for (int i = 0; i < NCH; i++) chk_rb(i, "R1 readback reset");
    chk(irq == 1'b0, "R1 irq reset", irq, 0);

    // R5 / R6 readback field writes
    wr(AW'(RB_BASE + 1), 16'hFFFF);
    exp_rb[1] = rb_wr(1, exp_rb[1], 16'hFFFF);
    chk_rb(1, "R5 scale/ref only");
    wr(AW'(RB_BASE + 5), 16'hFFFF);
    chk_rb(5, "R6 fixed channel ignores write");

    // R2 poll while disabled, then enable
    adc_din = 12'hA5C;
    wr(AW'(1), POLL | 16'h0004);
    repeat (C + 5) @(posedge clk);
    rd(AW'(1), v); chk(v == (POLL | 16'h0004), "R2 poll stays set", v, POLL | 16'h0004);
    chk(irq == 1'b0, "R2 no irq while disabled", irq, 0);
    chk_rb(2, "R2 readback untouched");
    wr(AW'(0), 16'h0001);
    wait_clear(k);
    chk(k == C + 1, "R2 starts on enable", k, C + 1);
    exp_rb[2] = rb_done(exp_rb[2], 12'hA5C);
    chk_rb(2, "R2 R4 result");
    rd(AW'(1), v); chk(v == 16'h0004, "R3 select bits kept", v, 16'h0004);
    wr(AW'(2), 16'h0001);

    // R4 keeps scale bits on channel 1
    convert(1, 12'h3C7, "ch1");

    // R3 lowest selected channel wins
    adc_din = 12'h123;
    wr(AW'(1), POLL | 16'h0048);
    wait_clear(k);
    exp_rb[3] = rb_done(exp_rb[3], 12'h123);
    chk_rb(3, "R3 lowest channel converted");
    chk_rb(6, "R3 higher channel untouched");
    wr(AW'(2), 16'h0001);

    // R8 control writes during conversion ignored
    adc_din = 12'h0F0;
    wr(AW'(1), POLL | 16'h0001);
    repeat (3) @(posedge clk);
    wr(AW'(1), 16'h0002);
    rd(AW'(1), v); chk(v == (POLL | 16'h0001), "R8 ctrl frozen", v, POLL | 16'h0001);
    wait_clear(k);
    chk(k > 0 && k <= C + 1, "R8 completion on time", k, C + 1);
    exp_rb[0] = rb_done(exp_rb[0], 12'h0F0);
    chk_rb(0, "R8 original channel converted");
    chk_rb(1, "R8 other channel untouched");
    rd(AW'(1), v); chk(v == 16'h0001, "R8 select after", v, 16'h0001);
    wr(AW'(2), 16'h0001);

    // R9 abort by disabling
    adc_din = 12'hBEE;
    wr(AW'(1), POLL | 16'h0002);
    repeat (4) @(posedge clk);
    wr(AW'(0), 16'h0000);
    repeat (C + 5) @(posedge clk);
    rd(AW'(1), v); chk(v[15] == 1'b1, "R9 poll stays set", v, POLL | 16'h0002);
    chk(irq == 1'b0, "R9 no irq", irq, 0);
    chk_rb(1, "R9 readback untouched");
    wr(AW'(0), 16'h0001);
    wait_clear(k);
    chk(k == C + 1, "R9 full latency restart", k, C + 1);
    exp_rb[1] = rb_done(exp_rb[1], 12'hBEE);
    chk_rb(1, "R9 result after restart");
    wr(AW'(2), 16'h0001);

    // R7 completion and clear in the same cycle: set wins
    adc_din = 12'h777;
    wr(AW'(1), POLL | 16'h0004);
    repeat (C) @(posedge clk);
    wr(AW'(2), 16'h0001);
    #0.5 chk(irq == 1'b1, "R7 set wins over clear", irq, 1);
    wr(AW'(2), 16'h0000);
    chk(irq == 1'b1, "R7 write zero no effect", irq, 1);
    wr(AW'(2), 16'h0001);
    chk(irq == 1'b0, "R7 later clear works", irq, 0);
    exp_rb[2] = rb_done(exp_rb[2], 12'h777);
    chk_rb(2, "R7 result stored");

    // random conversions
    for (int it = 0; it < 40; it++) begin
      int ch;
      logic [15:0] w;
      ch = int'($urandom_range(NCH - 1, 0));
      w = 16'($urandom);
      wr(AW'(RB_BASE + ch), w);
      exp_rb[ch] = rb_wr(ch, exp_rb[ch], w);
      chk_rb(ch, ch < FIXED_LO ? "R5 random field write" : "R6 random fixed write");
      convert(ch, 12'($urandom), "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule